// File: doc/BRIEF.md
# Accumulator Memory-Reference Sequencer

This block is the control unit and register datapath of a small 16-bit accumulator computer. It covers instruction fetch, the optional indirect-address step and the execute phase of the seven instructions that take a memory operand: bitwise AND into the accumulator, add into the accumulator with carry, load, store, unconditional jump, call (jump with the return address saved in memory) and increment-and-skip-if-zero. A 4-bit step counter drives a 4-to-16 one-hot timing decoder. A 3-to-8 decoder on the opcode field selects the operation. Every instruction is multi-cycle. Execution starts at step T4, and the step counter returns to zero on each instruction's last step.

The 4096 x 16 word memory sits inside the block. An external port loads it, and a second read port shows any word without disturbing execution. The `run` input lets the machine leave step T0. With `run` low the machine parks between instructions. `instr_done` is high during the last step of each instruction. Opcode 111 is outside this block's scope and only ends the instruction after the indirect step.

Top module: `acc_mref_seq`

## Requirements
- R1: After reset, AC, PC, E and the step counter are zero.
- R2: Fetch takes steps T0 to T2. It loads the word at PC as the instruction and adds one to PC. Bits 14:12 of the word are the opcode, bits 11:0 are the operand address and bit 15 selects indirect addressing.
- R3: When bit 15 is set, step T3 replaces the operand address with the low 12 bits of the memory word at that address. The upper bits of that word are ignored, and the cycle count is the same as for direct addressing.
- R4: Opcode 000 (AND) sets AC to AC AND M[ea], leaves E unchanged and takes 6 cycles.
- R5: Opcode 001 (ADD) sets AC to the low 16 bits of AC + M[ea] and E to the carry out, in 6 cycles. No other opcode changes E.
- R6: Opcode 010 (LDA) copies M[ea] into AC in 6 cycles.
- R7: Opcode 011 (STA) writes AC to M[ea] in 5 cycles and leaves AC unchanged.
- R8: Opcode 100 (BUN) loads PC with ea in 5 cycles.
- R9: Opcode 101 (BSA) writes the already-incremented PC, zero-extended, to M[ea] and sets PC to ea + 1, in 6 cycles.
- R10: Opcode 110 (ISZ) writes M[ea] + 1 back to M[ea] and adds one more to PC only when that result is zero, in 7 cycles.
- R11: Opcode 111 ends after step T3 (4 cycles) and changes neither AC, E nor memory.
- R12: At step T0 with `run` low, no register changes. Otherwise the step counter rises by one per cycle, never exceeds 6, and returns to 0 after the cycle in which `instr_done` is high.
- R13: `ld_en` writes `ld_data` to word `ld_addr` on the clock edge. `peek_data` shows the word at `peek_addr` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Allows a new instruction to start from step T0 |
| ld_en | input | 1 | Memory load strobe |
| ld_addr | input | 12 | Memory load address |
| ld_data | input | 16 | Memory load data |
| peek_addr | input | 12 | Inspection read address |
| peek_data | output | 16 | Word at peek_addr |
| ac | output | 16 | Accumulator |
| pc | output | 12 | Program counter |
| e_flag | output | 1 | Carry flip-flop |
| instr_done | output | 1 | High during the last step of an instruction |

## Verification
The bench runs one short program and measures the cycle count of every instruction. A decoder that fires the wrong step would show up as a 5 where 6 was expected, or as a missing ISZ T6 write.

Several corner cases are exercised directly:
- The ADD overflows to set E, and a later ADD clears it. An AND between them must keep E, which catches a design that writes E on every arithmetic step.
- ISZ runs once on 0xFFFF, where the wrap to zero must cause the skip, and once on an ordinary value, where no skip may happen. Skipping on the pre-increment value fails one of the two.
- BSA must store PC after the fetch increment, not the address of the BSA itself.
- The indirect pointer has junk in its upper bits, so a design that does not truncate the pointer to 12 bits loads from the wrong word.

// File: rtl/acc_pkg.sv
package acc_pkg;
    parameter int WORD_W  = 16;
    parameter int ADDR_W  = 12;
    parameter int SC_W    = 4;
    parameter int OP_W    = 3;
    parameter int OP_LO   = 12;
    parameter int IND_BIT = 15;
    parameter int LAST_T  = 6;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 3'd0,
        OP_ADD = 3'd1,
        OP_LDA = 3'd2,
        OP_STA = 3'd3,
        OP_BUN = 3'd4,
        OP_BSA = 3'd5,
        OP_ISZ = 3'd6,
        OP_RIO = 3'd7
    } op_e;

    typedef struct packed {
        logic [ADDR_W-1:0] ar;
        logic [ADDR_W-1:0] pc;
        logic [WORD_W-1:0] dr;
        logic [WORD_W-1:0] ac;
        logic [WORD_W-1:0] ir;
        logic              e;
        logic              ind;
        logic [SC_W-1:0]   sc;
    } regs_t;
endpackage

// File: rtl/onehot_dec.sv
module onehot_dec #(
    parameter int IN_W = 3
) (
    input  logic [IN_W-1:0]        code,
    output logic [(1<<IN_W)-1:0]   hot
);
    localparam int OUT_N = 1 << IN_W;

    for (genvar k = 0; k < OUT_N; k++) begin : g_line
        assign hot[k] = (code == IN_W'(k));
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] and_o,
    output logic [W-1:0] sum_o,
    output logic         carry_o,
    output logic [W-1:0] inc_o
);
    logic [W:0] wide_sum;

    assign wide_sum = {1'b0, a_in} + {1'b0, b_in};
    assign and_o    = a_in & b_in;
    assign sum_o    = wide_sum[W-1:0];
    assign carry_o  = wide_sum[W];
    assign inc_o    = b_in + W'(1);
endmodule

// File: rtl/mref_mem.sv
module mref_mem #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic [AW-1:0] peek_addr,
    output logic [DW-1:0] peek_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (ld_en) begin
            words[ld_addr] <= ld_data;
        end else if (cpu_we) begin
            words[cpu_addr] <= cpu_wdata;
        end
    end

    assign cpu_rdata = words[cpu_addr];
    assign peek_data = words[peek_addr];
endmodule

// File: rtl/acc_mref_seq.sv
module acc_mref_seq
    import acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [WORD_W-1:0] peek_data,
    output logic [WORD_W-1:0] ac,
    output logic [ADDR_W-1:0] pc,
    output logic              e_flag,
    output logic              instr_done
);
    localparam int T_N  = 1 << SC_W;
    localparam int D_N  = 1 << OP_W;
    localparam int PADW = WORD_W - ADDR_W;

    regs_t             q, d;
    logic [T_N-1:0]    t_hot;
    logic [D_N-1:0]    dsel;
    logic [WORD_W-1:0] mem_rdata;
    logic [WORD_W-1:0] mem_wdata;
    logic              mem_we;
    logic              done_c;
    logic              step_ok;
    logic              bad_step;
    logic [WORD_W-1:0] and_res, sum_res, dr_plus;
    logic              carry_res;
    logic [SC_W-1:0]   sc_now;

    onehot_dec #(.IN_W(SC_W)) u_tdec (
        .code (q.sc),
        .hot  (t_hot)
    );

    onehot_dec #(.IN_W(OP_W)) u_odec (
        .code (q.ir[OP_LO +: OP_W]),
        .hot  (dsel)
    );

    acc_alu #(.W(WORD_W)) u_alu (
        .a_in    (q.ac),
        .b_in    (q.dr),
        .and_o   (and_res),
        .sum_o   (sum_res),
        .carry_o (carry_res),
        .inc_o   (dr_plus)
    );

    mref_mem #(.AW(ADDR_W), .DW(WORD_W)) u_mem (
        .clk       (clk),
        .cpu_we    (mem_we),
        .cpu_addr  (q.ar),
        .cpu_wdata (mem_wdata),
        .cpu_rdata (mem_rdata),
        .ld_en     (ld_en),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .peek_addr (peek_addr),
        .peek_data (peek_data)
    );

    assign step_ok  = !(t_hot[0] && !run);
    assign bad_step = |t_hot[T_N-1:LAST_T+1];

    always_comb begin
        d         = q;
        mem_we    = 1'b0;
        mem_wdata = '0;
        done_c    = bad_step;
        if (step_ok) begin
            d.sc = q.sc + SC_W'(1);
        end
        if (t_hot[0] && run) begin
            d.ar = q.pc;
        end
        if (t_hot[1]) begin
            d.ir = mem_rdata;
            d.pc = q.pc + ADDR_W'(1);
        end
        if (t_hot[2]) begin
            d.ar  = q.ir[ADDR_W-1:0];
            d.ind = q.ir[IND_BIT];
        end
        if (t_hot[3]) begin
            if (dsel[OP_RIO]) begin
                done_c = 1'b1;
            end else if (q.ind) begin
                d.ar = mem_rdata[ADDR_W-1:0];
            end
        end
        if (t_hot[4]) begin
            if (dsel[OP_AND] || dsel[OP_ADD] || dsel[OP_LDA] || dsel[OP_ISZ]) begin
                d.dr = mem_rdata;
            end
            if (dsel[OP_STA]) begin
                mem_we    = 1'b1;
                mem_wdata = q.ac;
                done_c    = 1'b1;
            end
            if (dsel[OP_BUN]) begin
                d.pc   = q.ar;
                done_c = 1'b1;
            end
            if (dsel[OP_BSA]) begin
                mem_we    = 1'b1;
                mem_wdata = {{PADW{1'b0}}, q.pc};
                d.ar      = q.ar + ADDR_W'(1);
            end
        end
        if (t_hot[5]) begin
            if (dsel[OP_AND]) begin
                d.ac   = and_res;
                done_c = 1'b1;
            end
            if (dsel[OP_ADD]) begin
                d.ac   = sum_res;
                d.e    = carry_res;
                done_c = 1'b1;
            end
            if (dsel[OP_LDA]) begin
                d.ac   = q.dr;
                done_c = 1'b1;
            end
            if (dsel[OP_BSA]) begin
                d.pc   = q.ar;
                done_c = 1'b1;
            end
            if (dsel[OP_ISZ]) begin
                d.dr = dr_plus;
            end
        end
        if (t_hot[6] && dsel[OP_ISZ]) begin
            mem_we    = 1'b1;
            mem_wdata = q.dr;
            if (q.dr == '0) begin
                d.pc = q.pc + ADDR_W'(1);
            end
            done_c = 1'b1;
        end
        if (done_c) begin
            d.sc = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ac         = q.ac;
    assign pc         = q.pc;
    assign e_flag     = q.e;
    assign instr_done = done_c;
    assign sc_now     = q.sc;
endmodule

// File: rtl/acc_mref_chk.sv
module acc_mref_chk
    import acc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic [SC_W-1:0]   sc,
    input logic [WORD_W-1:0] ac,
    input logic [ADDR_W-1:0] pc,
    input logic              e_flag,
    input logic              instr_done
);
    AST_SC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        sc <= SC_W'(LAST_T)); // R12

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sc == '0 && !run) |=> ($stable(pc) && $stable(ac) && $stable(e_flag) && sc == '0)); // R12

    AST_DONE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |=> sc == '0); // R12

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        ((sc != '0 || run) && !instr_done) |=> sc == $past(sc) + SC_W'(1)); // R12

    AST_E_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(e_flag) |-> $past(sc) == SC_W'(5)); // R5

    AST_AC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ac) |-> $past(sc) == SC_W'(5)); // R6

    AST_PC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc) |-> ($past(sc) == SC_W'(1) || $past(sc) >= SC_W'(4))); // R8
endmodule

bind acc_mref_seq acc_mref_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .sc         (sc_now),
    .ac         (ac),
    .pc         (pc),
    .e_flag     (e_flag),
    .instr_done (instr_done)
);

// File: tb/acc_mref_seq_tb.sv
`timescale 1ns/1ps
module acc_mref_seq_tb;
    import acc_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n, run, ld_en;
    logic [ADDR_W-1:0] ld_addr, peek_addr;
    logic [WORD_W-1:0] ld_data, peek_data, ac;
    logic [ADDR_W-1:0] pc;
    logic              e_flag, instr_done;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    acc_mref_seq u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .ld_en(ld_en),
        .ld_addr(ld_addr), .ld_data(ld_data), .peek_addr(peek_addr),
        .peek_data(peek_data), .ac(ac), .pc(pc), .e_flag(e_flag),
        .instr_done(instr_done)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        check(act == exp, tag, act, exp);
    endtask

    task automatic load_word(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] w);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = w;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic peek(input logic [ADDR_W-1:0] a, output logic [WORD_W-1:0] w);
        peek_addr = a;
        #0.5;
        w = peek_data;
    endtask

    // Runs one instruction from T0 and returns its cycle count.
    task automatic step_instr(output int cyc);
        run = 1'b1;
        cyc = 0;
        for (int k = 0; k < 20; k++) begin
            cyc++;
            if (instr_done) break;
            @(negedge clk);
        end
        run = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk_eq("R1 ac", ac, 0);
        chk_eq("R1 pc", pc, 0);
        chk_eq("R1 e", e_flag, 0);
        chk_eq("R1 done", instr_done, 0);
    endtask

    task automatic t_load_add();
        int c;
        logic [WORD_W-1:0] w;
        peek(12'h101, w);
        chk_eq("R13 peek", w, 16'h9003);
        step_instr(c);
        chk_eq("R6 lda cycles", c, 6);
        chk_eq("R6 lda ac", ac, 16'h8001);
        chk_eq("R2 pc advance", pc, 12'h001);
        step_instr(c);
        chk_eq("R5 add cycles", c, 6);
        chk_eq("R5 add ac", ac, 16'h1004);
        chk_eq("R5 add carry", e_flag, 1);
    endtask

    task automatic t_store_and();
        int c;
        logic [WORD_W-1:0] w;
        step_instr(c);
        chk_eq("R7 sta cycles", c, 5);
        peek(12'h102, w);
        chk_eq("R7 sta mem", w, 16'h1004);
        chk_eq("R7 sta ac kept", ac, 16'h1004);
        step_instr(c);
        chk_eq("R4 and cycles", c, 6);
        chk_eq("R4 and ac", ac, 16'h0004);
        chk_eq("R4 and e kept", e_flag, 1);
    endtask

    task automatic t_branch_idle();
        int c;
        step_instr(c);
        chk_eq("R8 bun cycles", c, 5);
        chk_eq("R8 bun pc", pc, 12'h010);
        repeat (5) @(negedge clk);
        chk_eq("R12 idle pc", pc, 12'h010);
        chk_eq("R12 idle ac", ac, 16'h0004);
    endtask

    task automatic t_isz_bsa();
        int c;
        logic [WORD_W-1:0] w;
        step_instr(c);
        chk_eq("R10 isz cycles", c, 7);
        peek(12'h104, w);
        chk_eq("R10 isz wrap mem", w, 16'h0000);
        chk_eq("R10 isz skip pc", pc, 12'h012);
        step_instr(c);
        chk_eq("R9 bsa cycles", c, 6);
        peek(12'h020, w);
        chk_eq("R9 bsa saved", w, 16'h0013);
        chk_eq("R9 bsa pc", pc, 12'h021);
    endtask

    task automatic t_indirect_rio();
        int c;
        step_instr(c);
        chk_eq("R3 ind cycles", c, 6);
        chk_eq("R3 ind ac", ac, 16'h9003);
        step_instr(c);
        chk_eq("R11 rio cycles", c, 4);
        chk_eq("R11 rio ac", ac, 16'h9003);
        chk_eq("R11 rio e", e_flag, 1);
        chk_eq("R11 rio pc", pc, 12'h023);
    endtask

    task automatic t_isz_plain_add();
        int c;
        logic [WORD_W-1:0] w;
        step_instr(c);
        chk_eq("R10 isz noskip cycles", c, 7);
        peek(12'h105, w);
        chk_eq("R10 isz mem", w, 16'h0006);
        chk_eq("R10 isz noskip pc", pc, 12'h024);
        step_instr(c);
        chk_eq("R5 add2 ac", ac, 16'h9004);
        chk_eq("R5 add2 carry clear", e_flag, 0);
        peek(12'h022, w);
        chk_eq("R11 rio mem kept", w, 16'h7800);
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; run = 1'b0; ld_en = 1'b0;
        ld_addr = '0; ld_data = '0; peek_addr = '0;
        repeat (3) @(negedge clk);
        t_reset();
        load_word(12'h000, 16'h2100);
        load_word(12'h001, 16'h1101);
        load_word(12'h002, 16'h3102);
        load_word(12'h003, 16'h0103);
        load_word(12'h004, 16'h4010);
        load_word(12'h010, 16'h6104);
        load_word(12'h011, 16'h2105);
        load_word(12'h012, 16'h5020);
        load_word(12'h021, 16'hA030);
        load_word(12'h022, 16'h7800);
        load_word(12'h023, 16'h6105);
        load_word(12'h024, 16'h1106);
        load_word(12'h030, 16'hF101);
        load_word(12'h100, 16'h8001);
        load_word(12'h101, 16'h9003);
        load_word(12'h103, 16'h00FF);
        load_word(12'h104, 16'hFFFF);
        load_word(12'h105, 16'h0005);
        load_word(12'h106, 16'h0001);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_add();
        t_store_and();
        t_branch_idle();
        t_isz_bsa();
        t_indirect_rio();
        t_isz_plain_add();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule